// File: doc/BRIEF.md
# Run-Time Width Saturation Unit

This unit limits a 32-bit two's complement operand to a range whose size is selected on every cycle by a 5-bit width field and a mode bit. In signed mode the operand is held inside an n-bit two's complement range. In unsigned mode it is held inside 0 to 2^n − 1. A flag shows whether the value had to be limited.

The limit computation and comparison are purely combinational. A single register stage holds the result and the flag, so each operand presented at a rising clock edge appears at the outputs after that edge. A new operand, width and mode may be presented on every cycle. Typical use is at the end of a fixed-point datapath, where the required word size changes from one operation to the next.

Top module: `sat_unit`

## Requirements
- R1: The result and flag registered at a rising edge depend only on operand_i, width_i and mode_i sampled at that edge (latency one cycle), and new inputs may be applied every cycle.
- R2: While rst is high at a rising edge (synchronous, active high), result_o becomes 0 and clamped_o becomes 0 at that edge, whatever the other inputs are.
- R3: Signed mode is mode_i = 0. With width field k (k = n − 1, so n = k + 1), the result is the operand limited to the range −2^k to 2^k − 1.
- R4: In signed mode, field 31 passes every operand unchanged, field 15 limits to 0xFFFF8000..0x00007FFF and field 7 limits to 0xFFFFFF80..0x0000007F.
- R5: In signed mode with field 0 the only results are 0 and −1 (0xFFFFFFFF): a positive operand gives 0 and a negative operand gives 0xFFFFFFFF.
- R6: Unsigned mode is mode_i = 1. With width field n, the result is limited to 0 to 2^n − 1; field 31 gives at most 0x7FFFFFFF, 16 gives at most 0xFFFF and 8 gives at most 0xFF.
- R7: In unsigned mode every negative operand (bit 31 set) gives 0, for every width field.
- R8: In unsigned mode with width field 0 the result is always 0.
- R9: clamped_o is 1 exactly when result_o differs from the operand it was computed from.
- R10: An operand already inside the selected range passes unchanged with clamped_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | 32 | Two's complement operand |
| width_i | input | 5 | Width field: n − 1 in signed mode, n in unsigned mode |
| mode_i | input | 1 | 0 = signed range, 1 = unsigned range |
| result_o | output | 32 | Limited result, registered |
| clamped_o | output | 1 | 1 when the result differs from the operand, registered |

## Verification
The reset clear and a limiting operation can fall on the same edge: the bench holds an operand far outside the selected range, with a narrow width, while rst is high, both at start-up and again in mid-run, and requires a zero result with the flag low on that edge rather than the limited value. The other collision is a change of mode and width on consecutive cycles; a long sweep changes all three inputs on every cycle, and each output is judged against a behavioural integer model of the inputs sampled one edge earlier.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int SAT_DATA_W = 32;
    localparam int SAT_WID_W  = $clog2(SAT_DATA_W);

    typedef logic [SAT_DATA_W-1:0] sat_word_t;
    typedef logic [SAT_WID_W-1:0]  sat_wid_t;

    typedef enum logic {
        SAT_MODE_SIGNED   = 1'b0,
        SAT_MODE_UNSIGNED = 1'b1
    } sat_mode_e;

    typedef struct packed {
        sat_word_t upper;
        sat_word_t lower;
    } sat_bounds_t;

    typedef struct packed {
        sat_word_t value;
        logic      clamped;
    } sat_result_t;

    localparam sat_result_t SAT_RESULT_CLEAR = '{value: '0, clamped: 1'b0};

    // Signed comparison of two words held as plain vectors.
    function automatic logic sat_gt(input sat_word_t a, input sat_word_t b);
        return $signed(a) > $signed(b);
    endfunction

endpackage

// File: rtl/sat_limit_gen.sv
module sat_limit_gen
    import sat_pkg::*;
(
    input  sat_wid_t    width_i,
    input  sat_mode_e   mode_i,
    output sat_bounds_t bounds_o
);

    localparam int CMP_W = SAT_WID_W + 1;

    // Low-order mask: bit i is set when i lies below the field value.
    // The same mask is the upper limit in both modes.
    sat_word_t low_mask;

    for (genvar gi = 0; gi < SAT_DATA_W; gi++) begin : g_mask
        assign low_mask[gi] = ({1'b0, width_i} > CMP_W'(gi));
    end

    always_comb begin
        bounds_o.upper = low_mask;
        if (mode_i == SAT_MODE_SIGNED) begin
            bounds_o.lower = ~low_mask;
        end else begin
            bounds_o.lower = '0;
        end
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
(
    input  sat_word_t   operand_i,
    input  sat_bounds_t bounds_i,
    output sat_result_t result_o
);

    logic above;
    logic below;

    assign above = sat_gt(operand_i, bounds_i.upper);
    assign below = sat_gt(bounds_i.lower, operand_i);

    always_comb begin
        if (above) begin
            result_o.value = bounds_i.upper;
        end else if (below) begin
            result_o.value = bounds_i.lower;
        end else begin
            result_o.value = operand_i;
        end
        result_o.clamped = above | below;
    end

endmodule

// File: rtl/sat_out_stage.sv
module sat_out_stage
    import sat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sat_result_t d_i,
    output sat_result_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= SAT_RESULT_CLEAR;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/sat_unit.sv
module sat_unit
    import sat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SAT_DATA_W-1:0] operand_i,
    input  logic [SAT_WID_W-1:0]  width_i,
    input  logic                  mode_i,
    output logic [SAT_DATA_W-1:0] result_o,
    output logic                  clamped_o
);

    sat_mode_e   mode_sel;
    sat_bounds_t bounds;
    sat_result_t comb_res;
    sat_result_t reg_res;

    assign mode_sel = sat_mode_e'(mode_i);

    sat_limit_gen i_limit (
        .width_i  (width_i),
        .mode_i   (mode_sel),
        .bounds_o (bounds)
    );

    sat_clamp i_clamp (
        .operand_i (operand_i),
        .bounds_i  (bounds),
        .result_o  (comb_res)
    );

    sat_out_stage i_out (
        .clk (clk),
        .rst (rst),
        .d_i (comb_res),
        .q_o (reg_res)
    );

    assign result_o  = reg_res.value;
    assign clamped_o = reg_res.clamped;

    // Set when the previous edge saw reset released, so the outputs carry
    // a computed value and $past of the inputs refers to that edge.
    logic primed_q;
    always_ff @(posedge clk) begin
        primed_q <= ~rst;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result_o == '0) && !clamped_o); // R2

    AST_FLAG_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (clamped_o == (result_o != $past(operand_i)))); // R9

    AST_SIGNED_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !$past(mode_i) && ($past(width_i) == '1))
        |-> (result_o == $past(operand_i)) && !clamped_o); // R4

    AST_SIGNED_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !$past(mode_i) && ($past(width_i) == '0))
        |-> ((result_o == '0) || (result_o == '1))); // R5

    AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(mode_i)) |-> !result_o[SAT_DATA_W-1]); // R7

    AST_UNSIGNED_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(mode_i) && ($past(width_i) == '0))
        |-> (result_o == '0)); // R8

endmodule

// File: tb/test_sat_unit.sv
module test_sat_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [4:0]  width_i = '0;
    logic        mode_i = 1'b0;
    logic [31:0] result_o;
    logic        clamped_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    sat_unit i_sat_unit (
        .clk       (clk),
        .rst       (rst),
        .operand_i (operand_i),
        .width_i   (width_i),
        .mode_i    (mode_i),
        .result_o  (result_o),
        .clamped_o (clamped_o)
    );

    // Behavioural reference: wide integer arithmetic on the range formulas.
    function automatic void model(input logic [31:0] op, input logic [4:0] w,
                                  input logic m, output logic [31:0] r,
                                  output logic f);
        longint x, hi, lo, y;
        x = longint'($signed(op));
        if (!m) begin
            hi = (longint'(1) << w) - 1;
            lo = -(longint'(1) << w);
        end else begin
            hi = (longint'(1) << w) - 1;
            lo = 0;
        end
        if (x > hi)      y = hi;
        else if (x < lo) y = lo;
        else             y = x;
        r = y[31:0];
        f = (y != x);
    endfunction

    task automatic judge(input logic [31:0] er, input logic ef, input string tag);
        total++;
        if (result_o !== er || clamped_o !== ef) begin
            bad++;
            $display("FAIL %s: got result=%08h flag=%0b, expected result=%08h flag=%0b",
                     tag, result_o, clamped_o, er, ef);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, judge at the next falling edge.
    task automatic run(input logic [31:0] op, input logic [4:0] w, input logic m,
                       input logic [31:0] er, input logic ef, input string tag);
        logic [31:0] mr;
        logic        mf;
        operand_i = op; width_i = w; mode_i = m;
        @(negedge clk);
        judge(er, ef, tag);
        model(op, w, m, mr, mf);
        judge(mr, mf, {tag, " model"});
    endtask

    task automatic sweep(input logic [31:0] op, input logic [4:0] w, input logic m);
        logic [31:0] mr;
        logic        mf;
        model(op, w, m, mr, mf);
        operand_i = op; width_i = w; mode_i = m;
        @(negedge clk);
        judge(mr, mf, "R1 R3 R6 R9 sweep");
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: got cycles=%0d, expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] seed;
        seed = 32'h1234_5678;

        // R2: reset collides with a limiting operand.
        operand_i = 32'h7FFF_FFFF; width_i = 5'd0; mode_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        judge(32'h0, 1'b0, "R2 reset clear");
        rst = 1'b0;
        @(negedge clk);

        // Signed mode
        run(32'h7FFF_FFFF, 5'd31, 1'b0, 32'h7FFF_FFFF, 1'b0, "R4 signed 32 max");
        run(32'h8000_0000, 5'd31, 1'b0, 32'h8000_0000, 1'b0, "R4 signed 32 min");
        run(32'h7FFF_FFFF, 5'd15, 1'b0, 32'h0000_7FFF, 1'b1, "R4 signed 16 high");
        run(32'h8000_0000, 5'd15, 1'b0, 32'hFFFF_8000, 1'b1, "R4 signed 16 low");
        run(32'h7FFF_FFFF, 5'd7,  1'b0, 32'h0000_007F, 1'b1, "R4 signed 8 high");
        run(32'h8000_0000, 5'd7,  1'b0, 32'hFFFF_FF80, 1'b1, "R4 signed 8 low");
        run(32'h0000_0200, 5'd3,  1'b0, 32'h0000_0007, 1'b1, "R3 signed 4 high");
        run(32'hFFFF_FFF8, 5'd3,  1'b0, 32'hFFFF_FFF8, 1'b0, "R3 signed 4 edge");
        run(32'hFFFF_FFF7, 5'd3,  1'b0, 32'hFFFF_FFF8, 1'b1, "R3 signed 4 below");
        run(32'h7FFF_FFFF, 5'd0,  1'b0, 32'h0000_0000, 1'b1, "R5 signed 1 positive");
        run(32'h8000_0000, 5'd0,  1'b0, 32'hFFFF_FFFF, 1'b1, "R5 signed 1 negative");
        run(32'hFFFF_FFFF, 5'd0,  1'b0, 32'hFFFF_FFFF, 1'b0, "R5 signed 1 minus one");
        run(32'h0000_0005, 5'd7,  1'b0, 32'h0000_0005, 1'b0, "R10 signed in range");

        // Unsigned mode
        run(32'h7FFF_FFFF, 5'd31, 1'b1, 32'h7FFF_FFFF, 1'b0, "R6 unsigned 31");
        run(32'h7FFF_FFFF, 5'd16, 1'b1, 32'h0000_FFFF, 1'b1, "R6 unsigned 16");
        run(32'h7FFF_FFFF, 5'd8,  1'b1, 32'h0000_00FF, 1'b1, "R6 unsigned 8");
        run(32'h0000_0100, 5'd8,  1'b1, 32'h0000_00FF, 1'b1, "R6 unsigned 8 just over");
        run(32'h0000_00FF, 5'd8,  1'b1, 32'h0000_00FF, 1'b0, "R10 unsigned 8 top");
        run(32'h8000_0000, 5'd31, 1'b1, 32'h0000_0000, 1'b1, "R7 unsigned 31 negative");
        run(32'h8000_0000, 5'd16, 1'b1, 32'h0000_0000, 1'b1, "R7 unsigned 16 negative");
        run(32'hFFFF_FFFF, 5'd8,  1'b1, 32'h0000_0000, 1'b1, "R7 unsigned 8 minus one");
        run(32'h7FFF_FFFF, 5'd0,  1'b1, 32'h0000_0000, 1'b1, "R8 unsigned 0 positive");
        run(32'h0000_0000, 5'd0,  1'b1, 32'h0000_0000, 1'b0, "R8 unsigned 0 zero");
        run(32'h8000_0000, 5'd0,  1'b1, 32'h0000_0000, 1'b1, "R8 unsigned 0 negative");

        // R2 again: mid-run reset with a limiting operand on the same edge.
        rst = 1'b1;
        operand_i = 32'h8000_0000; width_i = 5'd2; mode_i = 1'b0;
        @(negedge clk);
        judge(32'h0, 1'b0, "R2 mid-run reset");
        rst = 1'b0;
        run(32'h8000_0000, 5'd2, 1'b0, 32'hFFFF_FFFC, 1'b1, "R1 first after reset");

        // R1, R3, R6, R9: every input changes on every cycle.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] op;
            seed = seed * 32'd1103515245 + 32'd12345;
            op = seed;
            case (i % 4)
                0: op = {{24{seed[31]}}, seed[7:0]};
                1: op = {{12{seed[30]}}, seed[19:0]};
                default: ;
            endcase
            sweep(op, seed[20:16], seed[29]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule